// File: doc/BRIEF.md
# Round-Robin Crossbar Matching Scheduler

This block decides, once per time slot, which inputs of an N-by-N switched backplane are connected to which outputs. Each input offers a vector naming the outputs for which it has traffic waiting. The block then runs a number of iterations of a three-step handshake. First every unmatched input asks for all its wanted outputs. Each output then grants one asker. Each input then accepts one grant. A grant goes to the first asker at or after the output's rotating pointer, and an accept goes to the first granting output at or after the input's rotating pointer.

Pointers move only when a grant is accepted in the first iteration of a slot. Later iterations fill in ports that are still free but leave every pointer alone. After the last iteration, the match is written to result registers and a one-cycle `done` pulse is raised. The controller has three states. ST_IDLE goes to ST_RUN when `start` is seen. ST_RUN stays in ST_RUN while iterations remain and goes to ST_REPORT after the last one. ST_REPORT always returns to ST_IDLE.

Top module: `rr_match_sched`

## Requirements
- R1: `start` is sampled in ST_IDLE. `busy` is high from the next cycle through the cycle of `done`. `done` is high for exactly one cycle, beginning at the (ITERS+1)-th rising edge counted from and including the edge that samples `start`.
- R2: In every iteration, each free output grants the first input, at or after its own pointer in increasing index order with wrap, that is free and requests it.
- R3: Each free input accepts the first output, at or after its own pointer with wrap, that granted it in that iteration.
- R4: When input i accepts output j, the input pointer becomes (j+1) mod N and the pointer of output j becomes (i+1) mod N.
- R5: Pointers change only on accepts made in the first iteration of a slot. Later iterations still match inputs and outputs left free by earlier ones.
- R6: In the result, no output is paired with more than one input, and no input with more than one output.
- R7: An input is only ever paired with an output that it requested in that slot.
- R8: `start` is ignored while `busy`. `req` is sampled only on the edge that accepts `start`.
- R9: Reset (active-low, asynchronous) clears all pointers to 0, clears the result to no matches, and returns the controller to ST_IDLE with `busy` and `done` low.
- R10: `match_valid` and `match_port` change only at the edge that raises `done`. They are held at all other times.
- R11: `req` bit i*N+j set means input i wants output j. `match_port` bits [i*PW +: PW] carry the output paired with input i. These bits are 0 when `match_valid[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a slot (sampled in ST_IDLE only) |
| req | input | N*N | Request matrix, bit i*N+j = input i wants output j |
| busy | output | 1 | A slot is being computed or reported |
| done | output | 1 | One-cycle pulse: result registers hold the new match |
| match_valid | output | N | Input i is paired in the latest result |
| match_port | output | N*PW | Output index per input, PW bits each |

## Verification
The block is tried with full request matrices, an empty matrix, sparse patterns, an anti-diagonal permutation, and every input contending for one output. Full matrices from a cleared state need all three iterations, which shows that later iterations fill free ports. Repeating the full matrix exposes whether those late matches wrongly moved a pointer. Repeated single-output contention must rotate the winner through every input, which pins the +1 pointer rule. The permutation followed by a full matrix shows that pointers spread apart until one iteration matches everything. Directed runs cover a `start` held during a slot with `req` changed, a reset in mid-slot, and results holding while `req` keeps changing.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_REPORT = 2'd2
    } rrm_state_e;

    // next index on a ring of n positions
    function automatic int unsigned rrm_wrap_inc(input int unsigned k, input int unsigned n);
        return (k + 1 >= n) ? 0 : k + 1;
    endfunction

endpackage

// File: rtl/rrm_rr_pick.sv
// Picks the first set candidate at or after ptr, scanning upward with wrap.
module rrm_rr_pick #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  pick
);

    always_comb begin
        logic          found;
        logic [PW:0]   idx;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = {1'b0, ptr} + (PW+1)'(k);
            if (idx >= (PW+1)'(N)) begin
                idx = idx - (PW+1)'(N);
            end
            if (!found && cand[idx[PW-1:0]]) begin
                pick[idx[PW-1:0]] = 1'b1;
                found             = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rrm_iter_stage.sv
// One grant/accept iteration over the free inputs and outputs.
module rrm_iter_stage #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0][N-1:0]      req,       // req[i][j]: input i wants output j
    input  logic [N-1:0]             in_free,
    input  logic [N-1:0]             out_free,
    input  logic [N-1:0][PW-1:0]     gptr,      // per output
    input  logic [N-1:0][PW-1:0]     aptr,      // per input
    output logic [N-1:0][N-1:0]      acc        // acc[i][j]: input i took output j
);

    logic [N-1:0][N-1:0] cand;   // cand[j][i]
    logic [N-1:0][N-1:0] gnt;    // gnt[j][i]
    logic [N-1:0][N-1:0] offer;  // offer[i][j]

    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                cand[j][i] = req[i][j] & in_free[i] & out_free[j];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_grant
        rrm_rr_pick #(.N(N), .PW(PW)) u_pick (
            .cand (cand[g]),
            .ptr  (gptr[g]),
            .pick (gnt[g])
        );

        assert_grant_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt[g]));
        assert_grant_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[g] & ~cand[g]) == '0);
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                offer[i][j] = gnt[j][i];
            end
        end
    end

    for (genvar a = 0; a < N; a++) begin : g_accept
        rrm_rr_pick #(.N(N), .PW(PW)) u_pick (
            .cand (offer[a]),
            .ptr  (aptr[a]),
            .pick (acc[a])
        );

        assert_accept_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(acc[a]));
        assert_accept_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (acc[a] & ~offer[a]) == '0);
    end

endmodule

// File: rtl/rrm_ptr_bank.sv
// Rotating pointers for outputs (grant side) and inputs (accept side).
module rrm_ptr_bank #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [N-1:0][N-1:0]  acc,
    output logic [N-1:0][PW-1:0] gptr,
    output logic [N-1:0][PW-1:0] aptr
);
    import rrm_pkg::*;

    logic [N-1:0][PW-1:0] gptr_d;
    logic [N-1:0][PW-1:0] aptr_d;

    always_comb begin
        gptr_d = gptr;
        aptr_d = aptr;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (acc[i][j]) begin
                    aptr_d[i] = PW'(rrm_wrap_inc(j, N));
                    gptr_d[j] = PW'(rrm_wrap_inc(i, N));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gptr <= '0;
            aptr <= '0;
        end else if (upd) begin
            gptr <= gptr_d;
            aptr <= aptr_d;
        end
    end

endmodule

// File: rtl/rr_match_sched.sv
module rr_match_sched #(
    parameter int N     = 4,
    parameter int ITERS = 3,
    parameter int PW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N*N-1:0]  req,
    output logic            busy,
    output logic            done,
    output logic [N-1:0]    match_valid,
    output logic [N*PW-1:0] match_port
);
    import rrm_pkg::*;

    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;

    rrm_state_e state_q, state_d;

    logic [CW-1:0]          cnt_q;
    logic [N-1:0][N-1:0]    req_q;
    logic [N-1:0]           in_used_q;
    logic [N-1:0]           out_used_q;
    logic [N-1:0]           wk_valid_q;
    logic [N-1:0][PW-1:0]   wk_port_q;
    logic [N-1:0]           res_valid_q;
    logic [N-1:0][PW-1:0]   res_port_q;

    logic [N-1:0][N-1:0]    acc;
    logic [N-1:0][PW-1:0]   gptr;
    logic [N-1:0][PW-1:0]   aptr;
    logic [N-1:0]           in_hit;
    logic [N-1:0]           out_hit;
    logic [N-1:0][PW-1:0]   hit_port;
    logic [N-1:0]           mrg_valid;
    logic [N-1:0][PW-1:0]   mrg_port;
    logic                   last_iter;
    logic                   upd;

    assign last_iter = (cnt_q == CW'(ITERS - 1));
    assign upd       = (state_q == ST_RUN) && (cnt_q == '0);

    rrm_ptr_bank #(.N(N), .PW(PW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .acc   (acc),
        .gptr  (gptr),
        .aptr  (aptr)
    );

    rrm_iter_stage #(.N(N), .PW(PW)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_q),
        .in_free  (~in_used_q),
        .out_free (~out_used_q),
        .gptr     (gptr),
        .aptr     (aptr),
        .acc      (acc)
    );

    // reduce this iteration's accepts
    always_comb begin
        in_hit   = '0;
        out_hit  = '0;
        hit_port = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (acc[i][j]) begin
                    in_hit[i]   = 1'b1;
                    out_hit[j]  = 1'b1;
                    hit_port[i] = PW'(j);
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            mrg_valid[i] = wk_valid_q[i] | in_hit[i];
            mrg_port[i]  = in_hit[i] ? hit_port[i] : wk_port_q[i];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RUN;
            ST_RUN:    if (last_iter) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RUN:    busy = 1'b1;
            ST_REPORT: begin busy = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end

    // slot working state and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            req_q       <= '0;
            in_used_q   <= '0;
            out_used_q  <= '0;
            wk_valid_q  <= '0;
            wk_port_q   <= '0;
            res_valid_q <= '0;
            res_port_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        req_q      <= req;
                        cnt_q      <= '0;
                        in_used_q  <= '0;
                        out_used_q <= '0;
                        wk_valid_q <= '0;
                        wk_port_q  <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q      <= cnt_q + 1'b1;
                    in_used_q  <= in_used_q | in_hit;
                    out_used_q <= out_used_q | out_hit;
                    wk_valid_q <= mrg_valid;
                    wk_port_q  <= mrg_port;
                    if (last_iter) begin
                        res_valid_q <= mrg_valid;
                        res_port_q  <= mrg_port;
                    end
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    assign match_valid = res_valid_q;
    assign match_port  = res_port_q;

    // result checks fed from result registers
    logic res_clash;
    logic res_unreq;
    always_comb begin
        res_clash = 1'b0;
        res_unreq = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (res_valid_q[i] && !req_q[i][res_port_q[i]]) res_unreq = 1'b1;
            for (int k = i + 1; k < N; k++) begin
                if (res_valid_q[i] && res_valid_q[k] && (res_port_q[i] == res_port_q[k]))
                    res_clash = 1'b1;
            end
        end
    end

    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_run_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last_iter) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));
    assert_ptr_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(gptr) && $stable(aptr)));
    assert_xbar_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !res_clash);
    assert_pairs_balance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ($countones(in_used_q) == $countones(out_used_q)));
    assert_match_requested_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !res_unreq);
    assert_req_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(req_q));
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_REPORT) |-> ($stable(res_valid_q) && $stable(res_port_q)));

endmodule

// File: tb/test_rr_match_sched.sv
module test_rr_match_sched;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int ITERS = 3;
    localparam int PW    = 2;
    localparam int NV    = 10;

    // vectors walked in order; pointer state carries from one to the next
    // req bit i*4+j = input i wants output j; port field i at bits [2i+1:2i]
    localparam logic [15:0] T_REQ [NV] = '{
        16'hFFFF,  // 0: from zero pointers, needs all three iterations (R5)
        16'hFFFF,  // 1: late matches of vector 0 did not move pointers (R5)
        16'h0000,  // 2: nothing requested
        16'h5004,  // 3: sparse, grant picks at/after pointer (R2, R3)
        16'h2222,  // 4: all contend for output 1 (R4 rotation)
        16'h2222,  // 5
        16'h2222,  // 6
        16'h2222,  // 7
        16'h1248,  // 8: anti-diagonal permutation
        16'hFFFF   // 9: desynchronised pointers give a full match in one pass
    };
    localparam logic [3:0] T_VAL [NV] = '{
        4'b0111, 4'b1111, 4'b0000, 4'b1001, 4'b0010,
        4'b0100, 4'b1000, 4'b0001, 4'b1111, 4'b1111
    };
    localparam logic [7:0] T_PORT [NV] = '{
        8'h24, 8'hE1, 8'h00, 8'h02, 8'h04,
        8'h10, 8'h40, 8'h01, 8'h1B, 8'h6C
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start;
    logic [N*N-1:0]  req;
    logic            busy;
    logic            done;
    logic [N-1:0]    match_valid;
    logic [N*PW-1:0] match_port;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rr_match_sched #(.N(N), .ITERS(ITERS), .PW(PW)) i_rr_match_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req         (req),
        .busy        (busy),
        .done        (done),
        .match_valid (match_valid),
        .match_port  (match_port)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one full slot with timing checks (R1) and result checks
    task automatic run_slot(input logic [15:0] r, input logic [3:0] ev, input logic [7:0] ep,
                            input string tag);
        @(negedge clk);
        req   = r;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq({tag, " R1 busy after start"}, 32'(busy), 32'd1);
        repeat (ITERS - 1) @(negedge clk);
        check_eq({tag, " R1 done not early"}, 32'(done), 32'd0);
        @(negedge clk);
        check_eq({tag, " R1 done on time"}, 32'(done), 32'd1);
        check_eq({tag, " R6/R7 match_valid"}, 32'(match_valid), 32'(ev));
        check_eq({tag, " R11 match_port"}, 32'(match_port), 32'(ep));
        @(negedge clk);
        check_eq({tag, " R1 done one cycle"}, 32'(done), 32'd0);
        check_eq({tag, " R1 idle after"}, 32'(busy), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        req   = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check_eq("R9 busy in reset", 32'(busy), 32'd0);
        check_eq("R9 done in reset", 32'(done), 32'd0);
        check_eq("R9 valid in reset", 32'(match_valid), 32'd0);
        check_eq("R9 port in reset", 32'(match_port), 32'd0);
        rst_n = 1'b1;

        // table: R2 R3 R4 R5 R6 R7 R11
        for (int v = 0; v < NV; v++) begin
            run_slot(T_REQ[v], T_VAL[v], T_PORT[v], $sformatf("R2/R3/R4/R5 vec%0d", v));
        end

        // R8: start held and req changed during a slot
        @(negedge clk);
        req   = 16'hFFFF;
        start = 1'b1;
        @(negedge clk);
        check_eq("R8 busy", 32'(busy), 32'd1);
        req = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check_eq("R8 no restart", 32'(done), 32'd0);
        @(negedge clk);
        check_eq("R8 done on time", 32'(done), 32'd1);
        check_eq("R8 valid from sampled req", 32'(match_valid), 32'hF);
        check_eq("R8 port from sampled req", 32'(match_port), 32'hB1);
        @(negedge clk);

        // R9: reset in mid-slot clears results and pointers
        req   = 16'hFFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_eq("R9 busy after mid reset", 32'(busy), 32'd0);
        check_eq("R9 valid after mid reset", 32'(match_valid), 32'd0);
        check_eq("R9 port after mid reset", 32'(match_port), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        run_slot(16'hFFFF, 4'b0111, 8'h24, "R9 pointers back to zero");

        // R10: result holds while req moves and no slot runs
        for (int k = 0; k < 4; k++) begin
            req = 16'(k * 16'h1357);
            @(negedge clk);
            check_eq("R10 valid held", 32'(match_valid), 32'h7);
            check_eq("R10 port held", 32'(match_port), 32'h24);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule